// File: doc/BRIEF.md
# Segment-Based Address Relocation Unit

This block turns a virtual address into a physical address through a table of eight segment descriptors. The top bits of each incoming virtual address select one descriptor; the remaining bits are an offset into that segment. The offset is compared with the descriptor's limit. If it fits, the descriptor's base is added to it. If the descriptor is not marked usable, or the offset runs past the limit, the unit returns a fault code in place of an address. An access that runs off the end of a segment, such as a stack that outgrows its allotment, therefore faults and never lands in the next region.

Privileged software fills the table through a simple write strobe with an index, a base, a limit and a usable flag. The request side takes one virtual address per cycle. It answers one clock later from a registered response stage that carries a response strobe, the physical address and a two-bit fault code.

Top module: `seg_xlate_unit`

## Requirements
- R1: The virtual address is split as {segment index, offset}. The index is the upper SEG_W bits (3 by default, giving 8 descriptors) and the offset is the lower VA_W-SEG_W bits (13 by default).
- R2: When the selected descriptor is usable and the offset is less than or equal to its limit, the response gives fault code 2'b00 and physical address base + offset, taken modulo 2^PA_W.
- R3: When the selected descriptor is usable and the offset is strictly greater than its limit, the response gives fault code 2'b10. An offset equal to the limit is accepted.
- R4: When the selected descriptor is not usable, the response gives fault code 2'b01, whatever the offset and limit are. The code 2'b11 never appears.
- R5: The physical address output is zero whenever the fault code is non-zero.
- R6: A request presented with req_valid high at a rising edge produces rsp_valid high for exactly the following cycle. While rsp_valid is low, rsp_paddr and rsp_fault are zero.
- R7: A descriptor write with cfg_we high takes effect at the rising edge. A translation sampled at that same edge uses the descriptor's previous contents.
- R8: Synchronous active-high reset marks every descriptor not usable and clears the response stage.
- R9: A descriptor write changes only the descriptor selected by cfg_idx.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | PA_W | Translated physical address, zero on fault |
| rsp_fault | output | 2 | 00 ok, 01 segment not usable, 10 offset beyond limit |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | SEG_W | Descriptor index to write |
| cfg_base | input | PA_W | Base to store |
| cfg_limit | input | VA_W-SEG_W | Highest legal offset to store |
| cfg_valid | input | 1 | Usable flag to store |

## Verification
The bench builds the unit with its default parameters: a 16-bit virtual address with 3 index bits and a 16-bit physical address. With these widths every descriptor is reachable, and so are the extremes of the offset range: a zero limit, a full 13-bit limit, and a base high enough that base + offset wraps past 16 bits. Offsets exactly at the limit and one above it are both driven. A write and a translation are aimed at the same descriptor in the same cycle to expose the old-contents rule. A mid-run reset shows that all descriptors become unusable again.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int DEF_VA_W  = 16;
    localparam int DEF_SEG_W = 3;
    localparam int DEF_PA_W  = 16;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_UNUSED  = 2'b01,
        FLT_OVERRUN = 2'b10
    } fault_e;

    typedef struct packed {
        logic   usable;
        logic   over;
    } probe_t;

    // Unusable descriptors win over the limit test.
    function automatic fault_e classify(input probe_t p);
        if (!p.usable) begin
            return FLT_UNUSED;
        end else if (p.over) begin
            return FLT_OVERRUN;
        end
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int IDX_W  = 3,
    parameter int BASE_W = 16,
    parameter int LIM_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_usable,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_usable
);
    localparam int NDESC = 1 << IDX_W;

    logic [BASE_W-1:0] base_q   [NDESC];
    logic [LIM_W-1:0]  limit_q  [NDESC];
    logic              usable_q [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_desc
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]   <= '0;
                limit_q[g]  <= '0;
                usable_q[g] <= 1'b0;
            end else if (hit) begin
                base_q[g]   <= wr_base;
                limit_q[g]  <= wr_limit;
                usable_q[g] <= wr_usable;
            end
        end
    end

    // Read is combinational on registered storage: a same-edge write is not seen.
    always_comb begin
        rd_base   = base_q[rd_idx];
        rd_limit  = limit_q[rd_idx];
        rd_usable = usable_q[rd_idx];
    end

endmodule

// File: rtl/seg_bound_calc.sv
module seg_bound_calc
    import seg_xlate_pkg::*;
#(
    parameter int OFS_W = 13,
    parameter int PA_W  = 16
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [PA_W-1:0]  base,
    input  logic [OFS_W-1:0] limit,
    input  logic             usable,
    output logic [PA_W-1:0]  paddr,
    output fault_e           fault
);
    logic [PA_W-1:0] ofs_ext;
    logic [PA_W-1:0] sum;
    probe_t          pr;

    always_comb begin
        ofs_ext   = PA_W'(offset);
        sum       = base + ofs_ext;
        pr.usable = usable;
        pr.over   = (offset > limit);
        fault     = classify(pr);
        paddr     = (fault == FLT_NONE) ? sum : '0;
    end

endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage
    import seg_xlate_pkg::*;
#(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [PA_W-1:0] in_paddr,
    input  fault_e          in_fault,
    output logic            out_valid,
    output logic [PA_W-1:0] out_paddr,
    output logic [1:0]      out_fault
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_paddr <= '0;
            out_fault <= FLT_NONE;
        end else begin
            out_valid <= in_valid;
            out_paddr <= in_valid ? in_paddr : '0;
            out_fault <= in_valid ? in_fault : FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int SEG_W = DEF_SEG_W,
    parameter int PA_W  = DEF_PA_W,
    localparam int OFS_W = VA_W - SEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFS_W-1:0] cfg_limit,
    input  logic             cfg_valid
);
    logic [SEG_W-1:0] seg_idx;
    logic [OFS_W-1:0] seg_ofs;
    logic [PA_W-1:0]  d_base;
    logic [OFS_W-1:0] d_limit;
    logic             d_usable;
    logic [PA_W-1:0]  calc_paddr;
    fault_e           calc_fault;

    assign seg_idx = req_vaddr[VA_W-1 -: SEG_W];
    assign seg_ofs = req_vaddr[OFS_W-1:0];

    seg_desc_table #(
        .IDX_W (SEG_W),
        .BASE_W(PA_W),
        .LIM_W (OFS_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_base  (cfg_base),
        .wr_limit (cfg_limit),
        .wr_usable(cfg_valid),
        .rd_idx   (seg_idx),
        .rd_base  (d_base),
        .rd_limit (d_limit),
        .rd_usable(d_usable)
    );

    seg_bound_calc #(
        .OFS_W(OFS_W),
        .PA_W (PA_W)
    ) u_calc (
        .offset(seg_ofs),
        .base  (d_base),
        .limit (d_limit),
        .usable(d_usable),
        .paddr (calc_paddr),
        .fault (calc_fault)
    );

    seg_rsp_stage #(
        .PA_W(PA_W)
    ) u_rsp (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_paddr (calc_paddr),
        .in_fault (calc_fault),
        .out_valid(rsp_valid),
        .out_paddr(rsp_paddr),
        .out_fault(rsp_fault)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault
);
    AST_FAULT_ZEROES_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'b00) |-> (rsp_paddr == '0)); // R5

    AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        rsp_fault != 2'b11); // R4

    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R6

    AST_NO_REQ_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_paddr == '0 && rsp_fault == 2'b00)); // R6

    AST_RESET_UNUSABLE: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && req_valid) |=> (rsp_fault == 2'b01)); // R8

endmodule

bind seg_xlate_unit seg_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

    localparam int VA_W  = 16;
    localparam int SEG_W = 3;
    localparam int PA_W  = 16;
    localparam int OFS_W = VA_W - SEG_W;
    localparam int NVEC  = 12;

    // {vaddr, expected paddr, expected fault}
    localparam logic [33:0] VEC [NVEC] = '{
        {16'h0123, 16'h1123, 2'd0},
        {16'h0FFF, 16'h1FFF, 2'd0},
        {16'h1000, 16'h0000, 2'd2},
        {16'h2100, 16'h4100, 2'd0},
        {16'h2101, 16'h0000, 2'd2},
        {16'h4000, 16'h0000, 2'd1},
        {16'h7800, 16'h0800, 2'd0},
        {16'h9FFF, 16'h0000, 2'd1},
        {16'hA000, 16'h2000, 2'd0},
        {16'hA001, 16'h0000, 2'd2},
        {16'hFFFF, 16'h9FFF, 2'd0},
        {16'hC000, 16'h0000, 2'd1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic [1:0]       rsp_fault;
    logic             cfg_we = 1'b0;
    logic [SEG_W-1:0] cfg_idx = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [OFS_W-1:0] cfg_limit = '0;
    logic             cfg_valid = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seg_xlate_unit i_seg_xlate_unit (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_limit(cfg_limit),
        .cfg_valid(cfg_valid)
    );

    task automatic check(input string req, input logic v, input logic [PA_W-1:0] pa,
                         input logic [1:0] f, input logic ev, input logic [PA_W-1:0] epa,
                         input logic [1:0] ef);
        checks++;
        if (v !== ev || pa !== epa || f !== ef) begin
            errors++;
            $display("FAIL %s: got valid=%0b pa=%h fault=%0d, expected valid=%0b pa=%h fault=%0d",
                     req, v, pa, f, ev, epa, ef);
        end
    endtask

    task automatic wr_desc(input int idx, input logic [PA_W-1:0] b,
                           input logic [OFS_W-1:0] l, input logic u);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_base = b; cfg_limit = l; cfg_valid = u;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xlate(input string req, input logic [VA_W-1:0] va,
                         input logic [PA_W-1:0] epa, input logic [1:0] ef);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, rsp_valid, rsp_paddr, rsp_fault, 1'b1, epa, ef);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got running, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset state", rsp_valid, rsp_paddr, rsp_fault, 1'b0, '0, 2'd0);
        rst = 1'b0;
        // R8: nothing written yet, every descriptor unusable
        xlate("R8 fresh table", 16'h0123, 16'h0000, 2'd1);
        // R6: response lasts one cycle only
        @(negedge clk);
        check("R6 idle after response", rsp_valid, rsp_paddr, rsp_fault, 1'b0, '0, 2'd0);

        wr_desc(0, 16'h1000, 13'h0FFF, 1'b1);
        wr_desc(1, 16'h4000, 13'h0100, 1'b1);
        wr_desc(3, 16'hF000, 13'h1FFF, 1'b1);
        wr_desc(5, 16'h2000, 13'h0000, 1'b1);
        wr_desc(7, 16'h8000, 13'h1FFF, 1'b1);

        // R1 split applies to every vector; fault code selects the tag
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] ef;
            ef = VEC[i][1:0];
            if (ef == 2'd0)
                xlate("R1 R2 relocation", VEC[i][33:18], VEC[i][17:2], ef);
            else if (ef == 2'd1)
                xlate("R1 R4 unusable", VEC[i][33:18], VEC[i][17:2], ef);
            else
                xlate("R1 R3 R5 over limit", VEC[i][33:18], VEC[i][17:2], ef);
        end

        // R7: write and translate the same descriptor in one cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_base = 16'h5000; cfg_limit = 13'h0100; cfg_valid = 1'b1;
        req_valid = 1'b1; req_vaddr = 16'h2010;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R7 old contents", rsp_valid, rsp_paddr, rsp_fault, 1'b1, 16'h4010, 2'd0);
        xlate("R7 new contents", 16'h2010, 16'h5010, 2'd0);
        // R9: neighbouring descriptors untouched
        xlate("R9 neighbour kept", 16'hA000, 16'h2000, 2'd0);
        xlate("R9 other kept", 16'h0123, 16'h1123, 2'd0);

        // R4: invalidating wins over the limit test
        wr_desc(0, 16'h1000, 13'h0FFF, 1'b0);
        xlate("R4 invalidated", 16'h0123, 16'h0000, 2'd1);
        xlate("R4 priority over limit", 16'h1000, 16'h0000, 2'd1);

        // R8: mid-run reset clears usable flags
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset clears response", rsp_valid, rsp_paddr, rsp_fault, 1'b0, '0, 2'd0);
        xlate("R8 after reset", 16'hFFFF, 16'h0000, 2'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule